// File: doc/BRIEF.md
# Digital PLL Tracking Mode Sequencer

This block is the top-level controller of a digital phase-locked loop. It steps the loop through four modes: frequency search, coarse tracking, fine tracking and frequency maintain. Each time the time-to-digital error detector offers a new signed phase-error sample, the sequencer takes at most one action. It drives the oscillator control word, sends a one-shot half-period correction word with a strobe, and reports the current mode.

In frequency search the control word is loaded from the measured reference period. Coarse tracking runs as four sample-driven steps:

1. Capture a first phase error.
2. Capture a second phase error. The difference between the two is the drift per cycle. A half-period word corrected by the phase error and the drift is issued for one half cycle.
3. Load the full period corrected by the drift.
4. Test whether the phase error is now below the detector's minimum range.

If it is, control passes to an external fine-tracking engine. Otherwise coarse tracking repeats. When the fine engine reports completion, the loop moves to frequency maintain. A watchdog sends the loop back to search from any mode. It trips when the phase-error magnitude exceeds twice the reference period.

The internal states are `ST_SEARCH`, `ST_C_FIRST`, `ST_C_SECOND`, `ST_C_HALF`, `ST_C_CHECK`, `ST_FINE` and `ST_MAINT`. The transitions are named start (search to first), capture (first to second), correct (second to half), settle (half to check), retry (check to first), hand-off (check to fine), finish (fine to maintain) and trip (any state to search). All arithmetic saturates at the signed limits of the word width.

Top module: `pll_track_seq`

## Requirements
- R1: After reset, `mode` is 0 (search), `dco_word` is 0 and `half_stb` is 0.
- R2: In search, an accepted sample without a watchdog trip loads `dco_word` with the reference period and moves to coarse tracking. The period is read as unsigned and saturated to the signed maximum.
- R3: An accepted sample whose magnitude is strictly greater than 2×`ref_period` trips the watchdog in any state. The watchdog returns the sequencer to search and reloads `dco_word` from the period. A magnitude equal to 2×`ref_period` does not trip it.
- R4: Without `err_valid`, `mode`, `dco_word` and the internal state do not change, whatever `phase_err`, `fine_done` and `ref_period` do.
- R5: Coarse step 1 stores the sample as e1. On step 2, with sample e2, the block computes eps = sat(e2−e1). It sets `half_word` = sat(floor(`dco_word`/2) + e2 + eps) and raises `half_stb` for exactly one cycle.
- R6: Coarse step 3 loads `dco_word` with sat(`dco_word` + eps).
- R7: On coarse step 4, a sample with magnitude strictly below `TDC_MIN` moves to fine tracking. Any other sample within the watchdog limit returns to coarse step 1.
- R8: In fine tracking, an accepted sample with `fine_done` high moves to maintain; otherwise the block stays in fine. Maintain is left only by a watchdog trip.
- R9: Every control-word and half-word result clamps to [−2^(W−1), 2^(W−1)−1].
- R10: `mode` encodes search = 0, coarse (all four steps) = 1, fine = 2, maintain = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | New phase-error sample strobe |
| phase_err | input | W | Signed phase error; positive means the divided clock leads |
| ref_period | input | W | Measured reference period, unsigned |
| fine_done | input | 1 | Fine-tracking engine finished |
| dco_word | output | W | Signed oscillator control word |
| half_word | output | W | Signed half-period correction word |
| half_stb | output | 1 | One-cycle strobe marking `half_word` valid |
| mode | output | 2 | Current tracking mode |

## Verification
The bench probes the watchdog at exactly 2×period and at one above it. A design using `>=` would drop a healthy loop back to search, and one using a narrow magnitude would miss large negative errors. It also probes the lock test at exactly `TDC_MIN` and one below it. An off-by-one here hands control to fine tracking too early or keeps the loop in coarse tracking for ever.

Drift values that overflow W bits check the clamping. A wrapping adder would turn a large positive correction negative. Idle cycles with `fine_done` toggling catch a sequencer that advances without a sample.

// File: rtl/pll_track_pkg.sv
package pll_track_pkg;

    typedef enum logic [1:0] {
        MODE_SEARCH = 2'd0,
        MODE_COARSE = 2'd1,
        MODE_FINE   = 2'd2,
        MODE_MAINT  = 2'd3
    } trk_mode_e;

    typedef enum logic [2:0] {
        ST_SEARCH   = 3'd0,
        ST_C_FIRST  = 3'd1,
        ST_C_SECOND = 3'd2,
        ST_C_HALF   = 3'd3,
        ST_C_CHECK  = 3'd4,
        ST_FINE     = 3'd5,
        ST_MAINT    = 3'd6
    } trk_state_e;

    // Clamp a wide signed value into a signed field of w bits (w <= 62).
    function automatic longint sat_clip(input longint v, input int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

endpackage

// File: rtl/pll_err_monitor.sv
module pll_err_monitor #(
    parameter int W       = 16,
    parameter int TDC_MIN = 8
) (
    input  logic signed [W-1:0] phase_err,
    input  logic        [W-1:0] ref_period,
    output logic                wd_trip,
    output logic                phase_locked
);
    localparam int XW = W + 2;

    logic signed [XW-1:0] err_ext;
    logic        [XW-1:0] mag;
    logic        [XW-1:0] limit;

    always_comb begin
        err_ext      = XW'(phase_err);
        mag          = (err_ext < 0) ? XW'(-err_ext) : XW'(err_ext);
        limit        = {1'b0, ref_period, 1'b0};
        wd_trip      = (mag > limit);
        phase_locked = (mag < XW'(TDC_MIN));
    end

    // A sample cannot be both a watchdog trip and inside the lock window (R3, R7).
    always_comb begin
        if (ref_period >= W'(TDC_MIN))
            assert_trip_lock_excl_R3: assert (!(wd_trip && phase_locked));
    end

endmodule

// File: rtl/pll_coarse_calc.sv
module pll_coarse_calc
    import pll_track_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_first,
    input  logic                cap_second,
    input  logic signed [W-1:0] sample,
    input  logic signed [W-1:0] ctl_word,
    output logic signed [W-1:0] half_word,
    output logic                half_stb,
    output logic signed [W-1:0] full_word
);
    logic signed [W-1:0] first_q;
    logic signed [W-1:0] drift_q;
    logic signed [W-1:0] drift_now;
    longint              half_wide;

    always_comb begin
        drift_now = W'(sat_clip(longint'(sample) - longint'(first_q), W));
        half_wide = (longint'(ctl_word) >>> 1) + longint'(sample) + longint'(drift_now);
        full_word = W'(sat_clip(longint'(ctl_word) + longint'(drift_q), W));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= '0;
            drift_q   <= '0;
            half_word <= '0;
            half_stb  <= 1'b0;
        end else begin
            half_stb <= cap_second;
            if (cap_first)
                first_q <= sample;
            if (cap_second) begin
                drift_q   <= drift_now;
                half_word <= W'(sat_clip(half_wide, W));
            end
        end
    end

    // The half-period strobe is a single-cycle pulse (R5).
    assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        half_stb |=> !half_stb);

    // The drift is only captured with a strobe, never between (R5).
    assert_drift_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_second |=> $stable(drift_q));

endmodule

// File: rtl/pll_track_seq.sv
module pll_track_seq
    import pll_track_pkg::*;
#(
    parameter int W       = 16,
    parameter int TDC_MIN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_valid,
    input  logic signed [W-1:0] phase_err,
    input  logic        [W-1:0] ref_period,
    input  logic                fine_done,
    output logic signed [W-1:0] dco_word,
    output logic signed [W-1:0] half_word,
    output logic                half_stb,
    output logic        [1:0]   mode
);
    trk_state_e          state_q, state_d;
    logic                wd_trip, phase_locked;
    logic                cap_first, cap_second, load_period, load_full;
    logic signed [W-1:0] full_word;
    logic signed [W-1:0] period_word;
    trk_mode_e           mode_e;

    pll_err_monitor #(.W(W), .TDC_MIN(TDC_MIN)) u_mon (
        .phase_err    (phase_err),
        .ref_period   (ref_period),
        .wd_trip      (wd_trip),
        .phase_locked (phase_locked)
    );

    pll_coarse_calc #(.W(W)) u_calc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_first  (cap_first),
        .cap_second (cap_second),
        .sample     (phase_err),
        .ctl_word   (dco_word),
        .half_word  (half_word),
        .half_stb   (half_stb),
        .full_word  (full_word)
    );

    assign period_word = W'(sat_clip(longint'($unsigned(ref_period)), W));

    // Next-state and step decode: all actions wait for an accepted sample.
    always_comb begin
        state_d     = state_q;
        cap_first   = 1'b0;
        cap_second  = 1'b0;
        load_period = 1'b0;
        load_full   = 1'b0;
        if (err_valid) begin
            if (wd_trip) begin
                state_d     = ST_SEARCH;   // trip
                load_period = 1'b1;
            end else begin
                unique case (state_q)
                    ST_SEARCH: begin
                        load_period = 1'b1;
                        state_d     = ST_C_FIRST;   // start
                    end
                    ST_C_FIRST: begin
                        cap_first = 1'b1;
                        state_d   = ST_C_SECOND;    // capture
                    end
                    ST_C_SECOND: begin
                        cap_second = 1'b1;
                        state_d    = ST_C_HALF;     // correct
                    end
                    ST_C_HALF: begin
                        load_full = 1'b1;
                        state_d   = ST_C_CHECK;     // settle
                    end
                    ST_C_CHECK: begin
                        state_d = phase_locked ? ST_FINE : ST_C_FIRST; // hand-off / retry
                    end
                    ST_FINE: begin
                        if (fine_done)
                            state_d = ST_MAINT;     // finish
                    end
                    ST_MAINT: state_d = ST_MAINT;
                    default:  state_d = ST_SEARCH;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    // Output register: control word.
    always_ff @(posedge clk) begin
        if (!rst_n)           dco_word <= '0;
        else if (load_period) dco_word <= period_word;
        else if (load_full)   dco_word <= full_word;
    end

    always_comb begin
        unique case (state_q)
            ST_SEARCH:                                    mode_e = MODE_SEARCH;
            ST_C_FIRST, ST_C_SECOND, ST_C_HALF, ST_C_CHECK: mode_e = MODE_COARSE;
            ST_FINE:                                      mode_e = MODE_FINE;
            ST_MAINT:                                     mode_e = MODE_MAINT;
            default:                                      mode_e = MODE_SEARCH;
        endcase
        mode = mode_e;
    end

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> $stable(dco_word) && $stable(state_q));

    assert_trip_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && wd_trip) |=> (mode == 2'd0));

    assert_maint_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAINT && !(err_valid && wd_trip)) |=> (state_q == ST_MAINT));

    assert_strobe_from_coarse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_stb) |-> (state_q == ST_C_HALF));

    assert_fine_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINE && $past(state_q) != ST_FINE) |-> $past(state_q) == ST_C_CHECK);

endmodule

// File: tb/pll_track_seq_bench.sv
`timescale 1ns/1ps
module pll_track_seq_bench;
    localparam int W       = 16;
    localparam int TDC_MIN = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                err_valid = 1'b0;
    logic signed [W-1:0] phase_err = '0;
    logic        [W-1:0] ref_period = '0;
    logic                fine_done = 1'b0;
    logic signed [W-1:0] dco_word, half_word;
    logic                half_stb;
    logic        [1:0]   mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    int cycles   = 0;

    // Bench reference model state
    int     m_st;      // 0 search,1 c1,2 c2,3 half,4 check,5 fine,6 maint
    longint m_word, m_e1, m_eps, m_half;
    bit     m_stb;
    string  m_tag;

    pll_track_seq #(.W(W), .TDC_MIN(TDC_MIN)) u_pll_track_seq (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .phase_err(phase_err),
        .ref_period(ref_period), .fine_done(fine_done), .dco_word(dco_word),
        .half_word(half_word), .half_stb(half_stb), .mode(mode)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 190000)", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    function automatic longint bsat(input longint v);
        longint hi = 32767;
        longint lo = -32768;
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    function automatic int exp_mode(input int st);
        if (st == 0) return 0;
        if (st <= 4) return 1;
        if (st == 5) return 2;
        return 3;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model(input bit v, input longint e, input longint p, input bit fd);
        longint mag = (e < 0) ? -e : e;
        m_stb = 1'b0;
        m_tag = "R4";
        if (!v) return;
        if (mag > 2 * p) begin
            m_st = 0; m_word = bsat(p); m_tag = "R3";
            return;
        end
        case (m_st)
            0: begin m_word = bsat(p); m_st = 1; m_tag = "R2"; end
            1: begin m_e1 = e; m_st = 2; m_tag = "R5"; end
            2: begin
                m_eps  = bsat(e - m_e1);
                m_half = bsat((m_word >>> 1) + e + m_eps);
                m_stb  = 1'b1; m_st = 3; m_tag = "R5";
            end
            3: begin m_word = bsat(m_word + m_eps); m_st = 4; m_tag = "R6"; end
            4: begin m_st = (mag < TDC_MIN) ? 5 : 1; m_tag = "R7"; end
            5: begin if (fd) m_st = 6; m_tag = "R8"; end
            default: m_tag = "R8";
        endcase
    endtask

    task automatic step(input bit v, input longint e, input longint p, input bit fd);
        @(negedge clk);
        err_valid  = v;
        phase_err  = W'(e);
        ref_period = W'(p);
        fine_done  = fd;
        @(posedge clk);
        #1;
        err_valid = 1'b0;
        model(v, e, p, fd);
        chk({m_tag, " mode (R10)"}, longint'(mode), longint'(exp_mode(m_st)));
        chk({m_tag, " dco_word"}, longint'(dco_word), m_word);
        chk({m_tag, " half_stb"}, longint'(half_stb), longint'(m_stb));
        if (m_stb) chk({m_tag, " half_word"}, longint'(half_word), m_half);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; err_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        m_st = 0; m_word = 0; m_e1 = 0; m_eps = 0; m_half = 0; m_stb = 0;
        chk("R1 mode", longint'(mode), 0);
        chk("R1 dco_word", longint'(dco_word), 0);
        chk("R1 half_stb", longint'(half_stb), 0);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        do_reset();

        // R2: search -> coarse with period word
        step(1, 0, 500, 0);
        // R4: idle cycles with noisy inputs
        for (int i = 0; i < 4; i++) step(0, 9999, 123, i[0]);
        // R5: e1=10, e2=30 -> eps 20, half 250+30+20=300
        step(1, 10, 500, 0);
        step(1, 30, 500, 0);
        chk("R5 half_word directed", longint'(half_word), 300);
        step(0, 0, 500, 0);
        chk("R5 strobe drop", longint'(half_stb), 0);
        // R6: word 520
        step(1, 0, 500, 0);
        chk("R6 word directed", longint'(dco_word), 520);
        // R7: magnitude == TDC_MIN not locked
        step(1, 8, 500, 0);
        chk("R7 retry at TDC_MIN", longint'(mode), 1);
        step(1, 0, 500, 0);
        step(1, 0, 500, 0);
        step(1, 0, 500, 0);
        step(1, -7, 500, 0);
        chk("R7 hand-off below TDC_MIN", longint'(mode), 2);
        // R8
        step(1, 3, 500, 0);
        step(0, 3, 500, 1);
        step(1, 3, 500, 1);
        chk("R8 maintain", longint'(mode), 3);
        // R3 boundary
        step(1, 1000, 500, 0);
        chk("R3 no trip at 2P", longint'(mode), 3);
        step(1, -1001, 500, 0);
        chk("R3 trip above 2P", longint'(mode), 0);
        chk("R3 reload", longint'(dco_word), 500);
        // R9 saturation
        step(1, 0, 65535, 0);
        chk("R9 period clamp", longint'(dco_word), 32767);
        step(1, -30000, 65535, 0);
        step(1, 30000, 65535, 0);
        chk("R9 half clamp", longint'(half_word), 32767);
        step(1, 0, 65535, 0);
        chk("R9 word clamp", longint'(dco_word), 32767);

        // Constrained random
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int     sel  = $urandom_range(0, 15);
            longint p    = longint'($urandom_range(200, 1000));
            longint e;
            bit     v    = ($urandom_range(0, 3) != 0);
            bit     fd   = ($urandom_range(0, 2) == 0);
            if (sel == 0)      e = 3 * p;
            else if (sel < 6)  e = longint'($urandom_range(0, 24)) - 12;
            else               e = longint'($urandom_range(0, 600)) - 300;
            if (sel == 1) e = (i[0]) ? 2 * p : -(2 * p + 1);
            step(v, e, p, fd);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule